// File: doc/BRIEF.md
# SPI Burst Master

This block is a memory-mapped SPI master that runs one chip-select-framed burst at a time. Software fills a byte-wide transmit queue. It programs two counts: the total number of bytes the burst exchanges, and how many of the first bytes are taken from the transmit queue. It then sets a go bit. The controller lowers chip select and shifts every byte in SPI mode 0, MSB first. Once the transmit count is used up, it sends 0x00 filler bytes. It captures the byte returned for every exchanged byte into a receive queue, and that includes the bytes returned while command bytes were going out.

A typical use is a flash read. Software queues a command and an address, sets the transmit count to that header length and sets the total count to the header plus the payload length. After the burst ends it reads back the whole receive queue and discards the header responses. The serial clock is the system clock divided by a fixed parameter. A soft reset aborts any burst, empties both queues and clears the configuration. Each queue can also be flushed on its own.

Top module: `spi_burst_master`

Register words, selected by `bus_addr`: 0 control, 1 total count, 2 transmit count, 3 status, 4 transmit data, 5 receive data.

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and the control and status words both read 0.
- R2: Writing the control word with bits 0, 1 and 2 set starts a burst. Chip select stays low for exactly 8 × total-count rising serial-clock edges. Control bit 2 reads 1 while the burst runs and 0 once chip select has returned high. A total count of 0 starts nothing.
- R3: The first min(transmit count, total count) bytes are taken from the transmit queue in write order and shifted out MSB first. Each byte taken lowers the transmit level, which status bits [22:16] report.
- R4: The bytes after the transmit count go out as 0x00 and leave the transmit queue untouched. A sourced byte position that finds the queue empty also sends 0x00. MOSI is low while chip select is high.
- R5: Each byte received during a burst, header bytes included, is pushed into the receive queue in arrival order. Status bits [6:0] give the receive level, and reading word 5 pops the oldest byte.
- R6: Reading word 5 while the receive queue is empty returns 0 and leaves the receive level at 0.
- R7: Writing control bit 31 aborts any burst and empties both queues. It also clears enable, master and both counts. Bit 31 reads 1 for SRST_CYCLES cycles after the write and then reads 0.
- R8: Writing control bit 4 empties the transmit queue and writing bit 5 empties the receive queue. Both bits read back as 0.
- R9: A go request is ignored, and chip select stays high, unless the same control write also sets enable (bit 0) and master (bit 1).
- R10: The serial clock runs with a period of CLK_DIV system clocks while chip select is low, and it stays low while chip select is high.
- R11: A transmit-data write to a full queue is dropped, and a received byte that meets a full receive queue is dropped. Neither level goes past FIFO_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier (pops the receive queue at word 5) |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with its defaults: queues 64 bytes deep, 8-bit counts, a divide-by-4 serial clock and a 4-cycle soft reset. With 64-byte queues, filling the transmit queue past its limit and running a 70-byte burst that overruns the receive queue both fit in a short run. The 8-bit counts let a random burst ask for more sourced bytes than the total count and more than the queue holds. A behavioural flash-side model answers at the pins, so it checks shift order, filler bytes and the serial-clock period without looking inside the block.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_TOTAL = 3'd1,
    REG_TXCNT = 3'd2,
    REG_STAT  = 3'd3,
    REG_TXD   = 3'd4,
    REG_RXD   = 3'd5
  } reg_word_e;

  localparam int CTL_EN    = 0;
  localparam int CTL_MST   = 1;
  localparam int CTL_GO    = 2;
  localparam int CTL_TXFL  = 4;
  localparam int CTL_RXFL  = 5;
  localparam int CTL_SRST  = 31;
  localparam int STAT_TXLO = 16;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter  int DEPTH = 64,
  parameter  int W     = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop, ptr_en;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == LW'(DEPTH));
  assign level   = cnt_q;
  assign dout    = mem[rd_q];
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign ptr_en  = flush | do_push | do_pop;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      if (do_push & ~do_pop)      cnt_d = cnt_q + 1'b1;
      else if (do_pop & ~do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (ptr_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine #(
  parameter  int DIV  = 4,
  parameter  int CW   = 8,
  localparam int DW   = $clog2(DIV),
  localparam int HALF = DIV / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          start,
  input  logic [CW-1:0] total,
  input  logic [CW-1:0] txcnt,
  input  logic          tx_empty,
  input  logic [7:0]    tx_head,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [7:0]    rx_byte,
  output logic          busy,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso
);
  logic          busy_q, busy_d, sclk_q, sclk_d;
  logic [DW-1:0] div_q, div_d;
  logic [2:0]    bit_q, bit_d;
  logic [CW-1:0] idx_q, idx_d, next_idx;
  logic [7:0]    sh_q, sh_d, rxs_q, rxs_d, load_byte;
  logic          last_div, mid_div, begin_b, byte_end, burst_end;
  logic          load, load_src, run_en;

  always_comb begin
    last_div  = (div_q == DW'(DIV - 1));
    mid_div   = (div_q == DW'(HALF - 1));
    begin_b   = start & ~busy_q & (total != '0) & ~abort;
    byte_end  = busy_q & last_div & (bit_q == 3'd7);
    burst_end = byte_end & (idx_q == total - 1'b1);
    next_idx  = begin_b ? '0 : idx_q + 1'b1;
    load      = begin_b | (byte_end & ~burst_end);
    load_src  = (next_idx < txcnt);
    load_byte = (load_src & ~tx_empty) ? tx_head : 8'h00;
    run_en    = begin_b | busy_q | abort;

    busy_d = busy_q;
    if (abort)          busy_d = 1'b0;
    else if (begin_b)   busy_d = 1'b1;
    else if (burst_end) busy_d = 1'b0;

    div_d  = (~busy_q | last_div) ? '0 : div_q + 1'b1;
    sclk_d = busy_q & ~abort & ~burst_end & (div_d >= DW'(HALF));
    bit_d  = begin_b ? 3'd0 : ((busy_q & last_div) ? bit_q + 3'd1 : bit_q);
    idx_d  = load ? next_idx : idx_q;
    sh_d   = load ? load_byte : ((busy_q & last_div) ? {sh_q[6:0], 1'b0} : sh_q);
    rxs_d  = (busy_q & mid_div) ? {rxs_q[6:0], miso} : rxs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      rxs_q  <= '0;
    end else if (run_en) begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      rxs_q  <= rxs_d;
    end
  end

  assign tx_pop  = load & load_src & ~tx_empty & ~abort;
  assign rx_push = byte_end & ~abort;
  assign rx_byte = rxs_q;
  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = busy_q & sh_q[7];
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter  int FIFO_DEPTH  = 64,
  parameter  int CNT_W       = 8,
  parameter  int CLK_DIV     = 4,
  parameter  int SRST_CYCLES = 4,
  localparam int LW          = $clog2(FIFO_DEPTH + 1),
  localparam int SW          = $clog2(SRST_CYCLES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n
);
  logic             en_q, en_d, mst_q, mst_d;
  logic [CNT_W-1:0] total_q, total_d, txcnt_q, txcnt_d;
  logic [SW-1:0]    srst_q, srst_d;
  logic             wr, rd, ctrl_wr, srst_req, srst_act, abort, start, cfg_en;
  logic             tx_flush, tx_push, tx_pop, tx_full, tx_empty;
  logic             rx_flush, rx_push, rx_pop, rx_full, rx_empty;
  logic [7:0]       tx_head, rx_head, rx_byte;
  logic [LW-1:0]    tx_level, rx_level;
  logic             busy;

  assign wr       = bus_sel & bus_wr;
  assign rd       = bus_sel & bus_rd;
  assign ctrl_wr  = wr & (bus_addr == REG_CTRL);
  assign srst_req = ctrl_wr & bus_wdata[CTL_SRST];
  assign srst_act = (srst_q != '0);
  assign abort    = srst_req | srst_act;
  assign start    = ctrl_wr & bus_wdata[CTL_EN] & bus_wdata[CTL_MST] & bus_wdata[CTL_GO];
  assign tx_flush = abort | (ctrl_wr & bus_wdata[CTL_TXFL]);
  assign rx_flush = abort | (ctrl_wr & bus_wdata[CTL_RXFL]);
  assign tx_push  = wr & (bus_addr == REG_TXD);
  assign rx_pop   = rd & (bus_addr == REG_RXD);
  assign cfg_en   = abort | wr;

  always_comb begin
    srst_d  = srst_req ? SW'(SRST_CYCLES) : (srst_act ? srst_q - 1'b1 : srst_q);
    en_d    = abort ? 1'b0 : (ctrl_wr ? bus_wdata[CTL_EN]  : en_q);
    mst_d   = abort ? 1'b0 : (ctrl_wr ? bus_wdata[CTL_MST] : mst_q);
    total_d = abort ? '0 :
              ((wr & (bus_addr == REG_TOTAL)) ? bus_wdata[CNT_W-1:0] : total_q);
    txcnt_d = abort ? '0 :
              ((wr & (bus_addr == REG_TXCNT)) ? bus_wdata[CNT_W-1:0] : txcnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q  <= '0;
      en_q    <= 1'b0;
      mst_q   <= 1'b0;
      total_q <= '0;
      txcnt_q <= '0;
    end else if (cfg_en) begin
      srst_q  <= srst_d;
      en_q    <= en_d;
      mst_q   <= mst_d;
      total_q <= total_d;
      txcnt_q <= txcnt_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_CTRL: begin
        bus_rdata[CTL_EN]   = en_q;
        bus_rdata[CTL_MST]  = mst_q;
        bus_rdata[CTL_GO]   = busy;
        bus_rdata[CTL_SRST] = srst_act;
      end
      REG_TOTAL: bus_rdata[CNT_W-1:0] = total_q;
      REG_TXCNT: bus_rdata[CNT_W-1:0] = txcnt_q;
      REG_STAT: begin
        bus_rdata[LW-1:0]             = rx_level;
        bus_rdata[STAT_TXLO +: LW]    = tx_level;
      end
      REG_RXD:  bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
      default:  bus_rdata = '0;
    endcase
  end

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push),
    .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_head),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push),
    .din(rx_byte), .pop(rx_pop), .dout(rx_head),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  spi_burst_engine #(.DIV(CLK_DIV), .CW(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .abort(abort), .start(start),
    .total(total_q), .txcnt(txcnt_q), .tx_empty(tx_empty), .tx_head(tx_head),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte), .busy(busy),
    .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
  );

  assign spi_cs_n = ~busy;
endmodule

// File: rtl/spi_burst_checker.sv
module spi_burst_checker #(
  parameter int LW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_sclk,
  input logic          spi_mosi,
  input logic          spi_cs_n,
  input logic          bus_sel,
  input logic          bus_rd,
  input logic [2:0]    bus_addr,
  input logic [31:0]   bus_rdata,
  input logic          srst_act,
  input logic          rx_full,
  input logic          rx_empty,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          rx_flush,
  input logic [LW-1:0] rx_level
);
  AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R10

  AST_IDLE_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_mosi); // R4

  AST_SRST_HOLDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_act |-> spi_cs_n); // R7

  AST_RX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rx_push && !rx_pop && !rx_flush) |=> $stable(rx_level)); // R11

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_rd && bus_addr == 3'd5 && rx_empty) |-> (bus_rdata == 32'd0)); // R6

  AST_EMPTY_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && !rx_push) |=> (rx_level == '0)); // R6
endmodule

bind spi_burst_master spi_burst_checker #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
  .spi_cs_n(spi_cs_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .srst_act(srst_act), .rx_full(rx_full),
  .rx_empty(rx_empty), .rx_push(rx_push), .rx_pop(rx_pop),
  .rx_flush(rx_flush), .rx_level(rx_level)
);

// File: tb/spi_burst_master_test.sv
`timescale 1ns/1ps
module spi_burst_master_test;
  logic        clk, rst_n, bus_sel, bus_wr, bus_rd, spi_miso;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        spi_sclk, spi_mosi, spi_cs_n;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  spi_burst_master uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Flash-side model
  logic [7:0] salt = 8'h00;
  logic [7:0] sl_out = 8'h00;
  logic [7:0] sl_in = 8'h00;
  logic [7:0] got [128];
  int   sl_bit = 0;
  int   sl_byte = 0;
  int   rises = 0;
  int   burst_rises = 0;
  realtime first_rise = 0, last_rise = 0;
  logic prev_cs = 1'b1;
  logic prev_sclk = 1'b0;

  function automatic logic [7:0] resp(int k, logic [7:0] s);
    return 8'(k * 29) ^ s ^ 8'h5A;
  endfunction

  assign spi_miso = sl_out[7];

  always @(spi_cs_n or spi_sclk) begin
    if (prev_cs === 1'b1 && spi_cs_n === 1'b0) begin
      sl_byte = 0;
      sl_bit = 0;
      burst_rises = 0;
      sl_out = resp(0, salt);
    end else if (spi_cs_n === 1'b0 && spi_sclk === 1'b1 && prev_sclk === 1'b0) begin
      sl_in = {sl_in[6:0], spi_mosi};
      sl_bit++;
      rises++;
      if (burst_rises == 0) first_rise = $realtime;
      last_rise = $realtime;
      burst_rises++;
      if (sl_bit == 8 && sl_byte < 128) got[sl_byte] = sl_in;
    end else if (spi_cs_n === 1'b0 && spi_sclk === 1'b0 && prev_sclk === 1'b1) begin
      if (sl_bit == 8) begin
        sl_byte++;
        sl_bit = 0;
        sl_out = resp(sl_byte, salt);
      end else begin
        sl_out = {sl_out[6:0], 1'b0};
      end
    end
    prev_cs = spi_cs_n;
    prev_sclk = spi_sclk;
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int i = 0; i < 5000; i++) begin
      bus_read(3'd0, c);
      if (!c[2]) break;
    end
  endtask

  // One randomised burst: T total, C sourced, L bytes loaded
  task automatic run_burst(int t, int c, int l);
    logic [7:0]  tx [64];
    logic [31:0] r;
    int srcd, pops, bad;
    bit ok;
    salt = 8'($urandom);
    bus_write(3'd0, 32'h33);
    for (int i = 0; i < l; i++) begin
      tx[i] = 8'($urandom);
      bus_write(3'd4, {24'd0, tx[i]});
    end
    bus_write(3'd1, t);
    bus_write(3'd2, c);
    bus_write(3'd0, 32'h7);
    bus_read(3'd0, r);
    check(r[2] == 1'b1 && spi_cs_n == 1'b0, "R2 busy during burst", r, 32'h7);
    wait_idle();
    check(spi_cs_n == 1'b1, "R2 cs high after burst", {31'd0, spi_cs_n}, 1);
    check(burst_rises == 8 * t, "R2 sclk edge count", burst_rises, 8 * t);
    check((last_rise - first_rise) == (8 * t - 1) * 20.0, "R10 sclk period",
          int'(last_rise - first_rise), (8 * t - 1) * 20);
    srcd = (c < t) ? c : t;
    pops = (srcd < l) ? srcd : l;
    bad = 0;
    for (int i = 0; i < t; i++) begin
      logic [7:0] e;
      e = (i < srcd && i < l) ? tx[i] : 8'h00;
      if (got[i] !== e) bad++;
    end
    check(bad == 0, "R3 R4 mosi bytes", bad, 0);
    bus_read(3'd3, r);
    check(r[6:0] == 7'(t), "R5 rx level", r[6:0], t);
    check(r[22:16] == 7'(l - pops), "R3 tx level after pops", r[22:16], l - pops);
    ok = 1;
    for (int i = 0; i < t; i++) begin
      bus_read(3'd5, r);
      if (r !== {24'd0, resp(i, salt)}) ok = 0;
    end
    check(ok, "R5 rx data order", 0, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int rb;
    void'($urandom(32'h5EED1234));
    bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    bus_read(3'd0, r);
    check(r == 0, "R1 ctrl reset", r, 0);
    bus_read(3'd3, r);
    check(r == 0, "R1 status reset", r, 0);
    check(spi_cs_n == 1 && spi_sclk == 0, "R1 pins reset", {spi_cs_n, spi_sclk}, 2);

    // R6 empty read
    bus_read(3'd5, r);
    check(r == 0, "R6 empty rx read", r, 0);
    bus_read(3'd3, r);
    check(r[6:0] == 0, "R6 rx level after empty read", r[6:0], 0);

    // Directed bursts: header then filler, short queue, over-count
    run_burst(4, 4, 4);
    run_burst(10, 4, 4);
    run_burst(6, 9, 9);
    run_burst(8, 5, 2);
    // Random bursts
    for (int n = 0; n < 10; n++) begin
      int t, c, l;
      t = 1 + int'($urandom % 20);
      c = int'($urandom % (t + 3));
      l = (n % 4 == 3) ? c / 2 : c + int'($urandom % 3);
      if (l > 64) l = 64;
      run_burst(t, c, l);
    end

    // R2 zero total
    rb = rises;
    bus_write(3'd0, 32'h33);
    bus_write(3'd1, 0);
    bus_write(3'd0, 32'h7);
    repeat (40) @(negedge clk);
    bus_read(3'd0, r);
    check(rises == rb && r[2] == 0, "R2 zero total starts nothing", rises - rb, 0);

    // R9 go without enable/master
    bus_write(3'd1, 3);
    bus_write(3'd0, 32'h4);
    repeat (40) @(negedge clk);
    check(rises == rb && spi_cs_n == 1, "R9 go without enable", rises - rb, 0);
    bus_write(3'd0, 32'h5);
    repeat (40) @(negedge clk);
    check(rises == rb && spi_cs_n == 1, "R9 go without master", rises - rb, 0);

    // R11 tx overflow, then R8 flush
    for (int i = 0; i < 66; i++) bus_write(3'd4, i);
    bus_read(3'd3, r);
    check(r[22:16] == 7'd64, "R11 tx level capped", r[22:16], 64);
    bus_write(3'd0, 32'h13);
    bus_read(3'd0, r);
    check(r[4] == 0 && r[5] == 0, "R8 flush bits read 0", r, 32'h3);
    bus_read(3'd3, r);
    check(r[22:16] == 0, "R8 tx flush", r[22:16], 0);

    // R11 rx overflow with a 70-byte burst
    salt = 8'h11;
    bus_write(3'd1, 70);
    bus_write(3'd2, 0);
    bus_write(3'd0, 32'h7);
    wait_idle();
    bus_read(3'd3, r);
    check(r[6:0] == 7'd64, "R11 rx level capped", r[6:0], 64);
    bus_read(3'd5, r);
    check(r == {24'd0, resp(0, 8'h11)}, "R5 first byte kept on overflow", r, resp(0, 8'h11));
    bus_write(3'd0, 32'h23);
    bus_read(3'd3, r);
    check(r[6:0] == 0, "R8 rx flush", r[6:0], 0);

    // R7 soft reset mid-burst
    for (int i = 0; i < 3; i++) bus_write(3'd4, 8'hA0 + i);
    bus_write(3'd1, 20);
    bus_write(3'd2, 2);
    bus_write(3'd0, 32'h7);
    repeat (50) @(negedge clk);
    bus_write(3'd0, 32'h8000_0000);
    bus_read(3'd0, r);
    check(r[31] == 1 && spi_cs_n == 1, "R7 srst reads 1 and aborts", r, 32'h8000_0000);
    repeat (8) @(negedge clk);
    bus_read(3'd0, r);
    check(r == 0, "R7 ctrl cleared after srst", r, 0);
    bus_read(3'd3, r);
    check(r == 0, "R7 queues emptied", r, 0);
    bus_read(3'd1, r);
    check(r == 0, "R7 total cleared", r, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule